// File: doc/BRIEF.md
# Three-Lane Token-Stall Deskew Buffer

This block sits between word alignment and symbol decoding in a three-channel TMDS receiver. Each channel arrives already cut into 10-bit words. Cable and receiver paths can still shift one channel by a few words against the others. The block gives each lane a small ring buffer. It fills all three buffers together once every lane reports that its word boundary is valid. After a short prefill it drains them one word per clock.

Skew is removed at blanking. The transmitter sends control tokens on all three channels at the same instant, and the block uses that boundary to line the lanes up. A lane whose buffer head is a control token stops reading while any other head still carries pixel data. When every head shows a token, the three lanes move on together. From then on the output words stand side by side in the same cycle.

A lock flag tells the decoder when the lanes have met at a token boundary. The buffers are flushed and the fill starts again in two cases: a lane loses its word boundary, or a stall would fill a buffer completely.

Top module: `tmds_lane_deskew`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all three output words are 0 and `lanes_locked` is 0.
- R2: While any of `ln0_ok`, `ln1_ok`, `ln2_ok` is low, nothing is written. The outputs stay 0 and `lanes_locked` stays 0.
- R3: Once all three ok inputs are high, every lane writes its input word on every clock. In steady running the outputs advance by one word per clock, in input order, with no word lost or repeated.
- R4: Reading starts only after 8 words per lane are stored. The word sampled at the first clock edge with all three ok inputs high appears on the outputs after the tenth such edge. Before that the outputs are 0.
- R5: The control tokens are the 10-bit values 0x354, 0x0AB, 0x154 and 0x2AB. A lane whose buffer head is one of these holds its read position while some other head is not a token, so its output keeps showing that token.
- R6: When all three heads are tokens, all lanes advance together. Lane skew of up to 6 words is absorbed, and the three outputs then carry equal words.
- R7: `lanes_locked` rises one clock after a read cycle in which all three heads are tokens and the previous read cycle did not show three tokens. The first read cycle after a fill counts as following a cycle without tokens.
- R8: A read cycle in which some, but not all, heads are tokens clears `lanes_locked` on the next clock.
- R9: Each lane buffer holds 16 words. If a stalled lane already holds 15 words, all buffers are flushed on that edge: the outputs become 0, `lanes_locked` clears, and the 8-word fill starts over.
- R10: A clock edge at which any ok input is low empties all buffers. It sets the outputs to 0 and clears `lanes_locked`. When all three ok inputs are high again, the fill restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ln0_word | input | 10 | Aligned word, lane 0 |
| ln1_word | input | 10 | Aligned word, lane 1 |
| ln2_word | input | 10 | Aligned word, lane 2 |
| ln0_ok | input | 1 | Lane 0 word boundary valid |
| ln1_ok | input | 1 | Lane 1 word boundary valid |
| ln2_ok | input | 1 | Lane 2 word boundary valid |
| out0_word | output | 10 | Deskewed word, lane 0 |
| out1_word | output | 10 | Deskewed word, lane 1 |
| out2_word | output | 10 | Deskewed word, lane 2 |
| lanes_locked | output | 1 | Lanes met at a token boundary |

## Verification
Several properties are checked on every cycle:
- A stalled head stays unchanged.
- Buffer occupancy never reaches 16.
- Running starts only after the prefill is reached.
- The lock flag rises only after three token heads, and drops after a partial token cycle.
- A flush or a lost ok stops reading and clears the outputs.

Other behaviour can only be shown by the bench scenarios. These are the exact latency of the first word, the absorption of 3- and 6-word skew into equal outputs, the re-alignment after a lane jumps, and the timing of an overflow flush and its refill.

// File: rtl/tmds_dsk_pkg.sv
`timescale 1ns/1ps
package tmds_dsk_pkg;
  localparam int NLANE  = 3;
  localparam int WORD_W = 10;

  typedef logic [WORD_W-1:0] word_t;

  // Shared fill state of all lanes
  typedef enum logic [1:0] {
    DSK_IDLE,
    DSK_FILL,
    DSK_RUN
  } dsk_st_e;

  // One of the four blanking-period control symbols
  function automatic logic is_ctrl_token(input word_t w);
    case (w)
      10'h354, 10'h0AB, 10'h154, 10'h2AB: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  // A lane reads unless it waits at a token while others still carry data
  function automatic logic lane_advances(input logic run, input logic own_tok,
                                         input logic every_tok);
    return run && (!own_tok || every_tok);
  endfunction

  // Enough words stored to begin reading
  function automatic logic fill_ready(input int lvl, input int thr);
    return lvl >= thr;
  endfunction

  // A held lane one write away from a full ring
  function automatic logic at_brink(input int lvl, input int depth);
    return lvl >= depth - 1;
  endfunction
endpackage

// File: rtl/dsk_lane_fifo.sv
`timescale 1ns/1ps
module dsk_lane_fifo
  import tmds_dsk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  word_t         wr_data,
  input  logic          rd_en,
  output word_t         head,
  output logic [PW-1:0] occ
);
  word_t         mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign head = mem[rd_ptr[AW-1:0]];
  assign occ  = wr_ptr - rd_ptr;

  // R9
  occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ < PW'(DEPTH));
endmodule

// File: rtl/dsk_ctrl.sv
`timescale 1ns/1ps
module dsk_ctrl
  import tmds_dsk_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int PREFILL = 8,
  parameter int PW      = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       all_ok,
  input  logic [NLANE-1:0]           tok,
  input  logic [NLANE-1:0][PW-1:0]   occ,
  output logic [NLANE-1:0]           rd_en,
  output logic                       wr_en,
  output logic                       clr,
  output logic                       running,
  output logic                       locked
);
  dsk_st_e          st;
  logic             prev_all_tok;
  logic             all_tok;
  logic             part_tok;
  logic [NLANE-1:0] hit;
  logic             brink;
  logic             go_run;
  logic             lock_set;
  logic             lock_drop;

  assign all_tok  = &tok;
  assign part_tok = (|tok) && !all_tok;
  assign running  = (st == DSK_RUN);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign rd_en[i] = lane_advances(running, tok[i], all_tok);
    assign hit[i]   = running && !rd_en[i] && at_brink(32'(occ[i]), DEPTH);
  end

  assign brink     = all_ok && (|hit);
  assign clr       = !all_ok || brink;
  assign wr_en     = all_ok && !brink;
  assign go_run    = (st == DSK_FILL) && fill_ready(32'(occ[0]), PREFILL);
  assign lock_set  = running && all_tok && !prev_all_tok;
  assign lock_drop = running && part_tok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= DSK_IDLE;
    end else if (clr) begin
      st <= all_ok ? DSK_FILL : DSK_IDLE;
    end else begin
      case (st)
        DSK_IDLE: st <= DSK_FILL;
        DSK_FILL: if (go_run) st <= DSK_RUN;
        default:  st <= DSK_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_all_tok <= 1'b0;
      locked       <= 1'b0;
    end else if (clr) begin
      prev_all_tok <= 1'b0;
      locked       <= 1'b0;
    end else if (running) begin
      prev_all_tok <= all_tok;
      if (lock_set)       locked <= 1'b1;
      else if (lock_drop) locked <= 1'b0;
    end
  end

  // R4
  fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(occ[0]) >= PW'(PREFILL));

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(running && all_tok));

  // R8
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && part_tok |=> !locked);

  // R9
  brink_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brink |=> !running && !locked);
endmodule

// File: rtl/tmds_lane_deskew.sv
`timescale 1ns/1ps
module tmds_lane_deskew
  import tmds_dsk_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int PREFILL = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] ln0_word,
  input  logic [9:0] ln1_word,
  input  logic [9:0] ln2_word,
  input  logic       ln0_ok,
  input  logic       ln1_ok,
  input  logic       ln2_ok,
  output logic [9:0] out0_word,
  output logic [9:0] out1_word,
  output logic [9:0] out2_word,
  output logic       lanes_locked
);
  localparam int PW = $clog2(DEPTH) + 1;

  word_t                     in_w  [NLANE];
  word_t                     head  [NLANE];
  word_t                     out_q [NLANE];
  logic [NLANE-1:0]          tok;
  logic [NLANE-1:0][PW-1:0]  occ_v;
  logic [NLANE-1:0]          rd_en;
  logic                      all_ok;
  logic                      tok_all;
  logic                      wr_en;
  logic                      clr;
  logic                      running;
  logic                      locked;

  assign in_w[0] = ln0_word;
  assign in_w[1] = ln1_word;
  assign in_w[2] = ln2_word;
  assign all_ok  = ln0_ok && ln1_ok && ln2_ok;
  assign tok_all = &tok;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    dsk_lane_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_en   (wr_en),
      .wr_data (in_w[i]),
      .rd_en   (rd_en[i]),
      .head    (head[i]),
      .occ     (occ_v[i])
    );

    assign tok[i] = is_ctrl_token(head[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 out_q[i] <= '0;
      else if (clr || !running)   out_q[i] <= '0;
      else                        out_q[i] <= head[i];
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && !rd_en[i] && !clr |=> head[i] == $past(head[i]));
  end

  dsk_ctrl #(.DEPTH(DEPTH), .PREFILL(PREFILL), .PW(PW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .all_ok  (all_ok),
    .tok     (tok),
    .occ     (occ_v),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .clr     (clr),
    .running (running),
    .locked  (locked)
  );

  assign out0_word    = out_q[0];
  assign out1_word    = out_q[1];
  assign out2_word    = out_q[2];
  assign lanes_locked = locked;

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok |=> !lanes_locked && out0_word == '0 && out1_word == '0 && out2_word == '0);

  // R6
  joint_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && tok_all && !clr |=>
      is_ctrl_token(out0_word) && is_ctrl_token(out1_word) && is_ctrl_token(out2_word));
endmodule

// File: tb/sim_tmds_lane_deskew.sv
`timescale 1ns/1ps
module sim_tmds_lane_deskew;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] ln0_word = '0, ln1_word = '0, ln2_word = '0;
  logic       ln0_ok = 1'b0, ln1_ok = 1'b0, ln2_ok = 1'b0;
  logic [9:0] out0_word, out1_word, out2_word;
  logic       lanes_locked;

  int         nchk = 0;
  int         nerr = 0;
  int         t = 0;
  int         mode = 0;
  int         dly [3] = '{0, 0, 0};
  logic [2:0] okv = 3'b000;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tmds_lane_deskew u0 (
    .clk(clk), .rst_n(rst_n),
    .ln0_word(ln0_word), .ln1_word(ln1_word), .ln2_word(ln2_word),
    .ln0_ok(ln0_ok), .ln1_ok(ln1_ok), .ln2_ok(ln2_ok),
    .out0_word(out0_word), .out1_word(out1_word), .out2_word(out2_word),
    .lanes_locked(lanes_locked)
  );

  // Line of 40 words: 8 tokens, then 32 data words in 0x380..0x3FF
  function automatic logic [9:0] pat(input int p);
    int pos;
    pos = p % 40;
    if (pos < 8) begin
      case (pos % 4)
        0: return 10'h354;
        1: return 10'h0AB;
        2: return 10'h154;
        default: return 10'h2AB;
      endcase
    end
    return {3'b111, p[6:0]};
  endfunction

  function automatic logic [9:0] lane_in(input int lane);
    if (mode == 1) return (lane == 0) ? 10'h354 : {3'b111, t[6:0]};
    return pat(t - dly[lane]);
  endfunction

  task automatic chk(input bit good, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!good) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    ln0_word = lane_in(0);
    ln1_word = lane_in(1);
    ln2_word = lane_in(2);
    ln0_ok = okv[0];
    ln1_ok = okv[1];
    ln2_ok = okv[2];
    @(posedge clk);
    @(negedge clk);
    t++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    okv = 3'b000;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  task automatic watch_aligned(input int n, input string req);
    int bad = 0;
    int dat = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (!(out0_word == out1_word && out1_word == out2_word && lanes_locked)) bad++;
      if (out0_word[9:7] == 3'b111) dat++;
    end
    chk(bad == 0, req, bad, 0);
    chk(dat > 0, req, dat, 1);
  endtask

  task automatic test_reset();
    do_reset();
    // R1
    chk(out0_word == 0 && out1_word == 0 && out2_word == 0, "R1 outputs after reset",
        {out0_word, out1_word}, 0);
    chk(!lanes_locked, "R1 lock after reset", lanes_locked, 0);
  endtask

  task automatic test_partial_ok();
    mode = 0;
    dly = '{0, 0, 0};
    okv = 3'b011;
    repeat (20) tick();
    // R2
    chk(out0_word == 0 && out1_word == 0 && out2_word == 0 && !lanes_locked,
        "R2 one lane not ok", {out0_word, lanes_locked}, 0);
  endtask

  task automatic test_prefill();
    okv = 3'b111;
    t = 0;
    repeat (9) tick();
    // R4: nothing out after nine edges
    chk(out0_word == 0 && !lanes_locked, "R4 before first word", out0_word, 0);
    tick();
    // R4: first word after the tenth edge
    chk(out0_word == 10'h354 && out1_word == 10'h354 && out2_word == 10'h354,
        "R4 first word", out0_word, 10'h354);
    // R7: fresh run starting on tokens
    chk(lanes_locked, "R7 lock on fresh token start", lanes_locked, 1);
    tick();
    // R3
    chk(out0_word == 10'h0AB, "R3 next word", out0_word, 10'h0AB);
    tick();
    // R5: all tokens advance together
    chk(out1_word == 10'h154, "R5 token advance", out1_word, 10'h154);
    tick();
    chk(out2_word == 10'h2AB, "R5 token advance", out2_word, 10'h2AB);
  endtask

  task automatic test_skew(input int a, input int b, input int c, input string req);
    do_reset();
    mode = 0;
    dly = '{a, b, c};
    okv = 3'b111;
    t = 14;
    repeat (20) tick();
    // R7: no lock before the first token boundary
    chk(!lanes_locked, "R7 no lock before boundary", lanes_locked, 0);
    repeat (200) tick();
    watch_aligned(80, req);
  endtask

  task automatic test_resync();
    bit seen0 = 1'b0;
    dly[2] = 3;
    for (int k = 0; k < 120; k++) begin
      tick();
      if (!lanes_locked) seen0 = 1'b1;
    end
    // R8
    chk(seen0, "R8 lock drops on partial tokens", seen0, 1);
    watch_aligned(80, "R6 realigned after jump");
  endtask

  task automatic test_ok_loss();
    while ((t % 40) != 13) tick();
    okv[1] = 1'b0;
    tick();
    // R10
    chk(out0_word == 0 && out1_word == 0 && out2_word == 0, "R10 outputs cleared",
        out0_word, 0);
    chk(!lanes_locked, "R10 lock cleared", lanes_locked, 0);
    okv = 3'b111;
    repeat (200) tick();
    watch_aligned(80, "R10 relock after restart");
  endtask

  task automatic test_overflow();
    do_reset();
    mode = 1;
    okv = 3'b111;
    t = 0;
    repeat (15) tick();
    // R5: token lane holds while data lanes read
    chk(out0_word == 10'h354, "R5 stalled lane shows token", out0_word, 10'h354);
    chk(out1_word == 10'h385 && out2_word == 10'h385, "R5 data lanes keep reading",
        out1_word, 10'h385);
    tick();
    // R9
    chk(out0_word == 0 && out1_word == 0 && !lanes_locked, "R9 flush at 15 words",
        out1_word, 0);
    repeat (9) tick();
    chk(out1_word == 0, "R9 refill in progress", out1_word, 0);
    tick();
    chk(out1_word == 10'h390, "R9 restart after refill", out1_word, 10'h390);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_partial_ok();
    test_prefill();
    test_skew(0, 3, 1, "R6 three-word skew");
    test_resync();
    test_ok_loss();
    test_skew(6, 0, 3, "R6 six-word skew");
    test_overflow();
    summary();
  end

  initial begin
    #750000;
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", t);
    summary();
  end
endmodule